// File: doc/BRIEF.md
# Multi-Cycle Instruction Cycle Sequencer

This block is the control unit and register datapath of a small accumulator machine. It steps each instruction through separate phases over a single-port memory: a fetch phase, an optional indirect phase, an execute phase and, when an interrupt is pending and enabled, an interrupt-entry phase. Every phase moves data through explicit registers: a program counter, a memory address register, a memory buffer register and an instruction register. The memory address register always drives the memory address bus, and the memory buffer register always drives the write data.

The block is meant to sit in front of any memory that completes a request by raising a ready signal after zero or more wait cycles. On interrupt entry it saves the return address on a downward-growing stack. It then reads a handler address from a vector table of 256 32-bit words, indexed by the interrupt number, and resumes fetching at that handler.

Top module: `icyc_core`

## Requirements
- R1: While rst_ni is low, pc_o, acc_o and flags_o are zero, int_en_o is 0 and mem_req_o is 0.
- R2: An instruction word is split as opcode in bits [31:24], indirect flag in bit 23 and address in bits [22:0]. The opcodes are 0x01 load, 0x02 store, 0x03 add, 0x04 jump, 0x05 jump-if-zero, 0x06 enable interrupts and 0x07 disable interrupts. Any other opcode does nothing.
- R3: A fetch puts the program counter on the address bus, reads the word into the buffer register and then into the instruction register, and advances the program counter by exactly one.
- R4: When bit 23 is set, an extra read is made at the instruction's address field, and the low 23 bits of the returned word become the operand address.
- R5: Once mem_req_o is high, it stays high until mem_rdy_i is seen. Address, write data and mem_we_o stay stable while it waits. mem_we_o is high only together with mem_req_o.
- R6: Load copies the operand into the accumulator. Add adds the operand to it. Store writes the accumulator to the operand address. flags_o holds zero in bit 0, sign in bit 1, carry in bit 2 and signed overflow in bit 3. Add updates all four flags. Load sets zero and sign and clears carry and overflow.
- R7: Jump loads the operand address into the program counter. Jump-if-zero does so only when the zero flag is set; otherwise execution falls through.
- R8: A pending irq_i is taken only at the end of an instruction, and only if the interrupt enable was already set when that instruction began executing. A change made by enable or disable therefore first counts at the end of the next instruction.
- R9: Interrupt entry clears the enable and decrements the stack pointer by one. It writes the return program counter to the new stack address, reads the word at VEC_BASE plus irq_num_i, and loads the low 23 bits of that word into the program counter.
- R10: While the interrupt enable is clear, irq_i has no effect on execution or on memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| irq_num_i | input | 8 | Interrupt number, indexes the vector table |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 23 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_rdy_i | input | 1 | Memory has completed the request |
| pc_o | output | 23 | Program counter |
| acc_o | output | 32 | Accumulator |
| flags_o | output | 4 | Flags: overflow, carry, sign, zero (bit 3 down to 0) |
| int_en_o | output | 1 | Interrupt enable |

## Verification
The bench runs programs against memory latencies of zero, one and two wait cycles. A sequencer that sampled data before ready, or changed the address during a wait, would store wrong values or hit the wrong locations. Jump-if-zero is tested both taken and not taken: a flag read one cycle late would let a skipped store through or drop a real one. Add is pushed through a carry-out to zero and through a signed overflow, so a wrong carry or overflow term appears in flags_o. Two interrupt cases are covered. With the line held high but the enable clear, an extra stack write would show up as an unexpected store. With the enable set, a sequencer that did not clear it would re-enter and push a second time, and a wrong vector index or return value would change the stored data.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [3:0] {
    S_FA, S_FM, S_FI, S_DC, S_IM,
    S_XA, S_XM, S_XW,
    S_NA, S_NW, S_VA, S_VM, S_VL
  } state_e;

  typedef enum logic [1:0] {MAR_PC, MAR_MBR, MAR_SP, MAR_VEC} mar_sel_e;
  typedef enum logic [1:0] {MBR_MEM, MBR_ACC, MBR_PC} mbr_sel_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ADD} acc_op_e;

  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_ADD   = 8'h03;
  localparam logic [7:0] OP_JMP   = 8'h04;
  localparam logic [7:0] OP_JZ    = 8'h05;
  localparam logic [7:0] OP_EI    = 8'h06;
  localparam logic [7:0] OP_DI    = 8'h07;

  typedef struct packed {
    logic     mar_ld;
    mar_sel_e mar_sel;
    logic     mbr_ld;
    mbr_sel_e mbr_sel;
    logic     ir_ld;
    logic     pc_inc;
    logic     pc_ld;
    acc_op_e  acc_op;
    logic     sp_dec;
    logic     ie_set;
    logic     ie_clr;
    logic     num_ld;
    logic     mem_req;
    logic     mem_we;
  } ctl_t;

endpackage

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] opcode_i,
  input  logic           ind_i,
  input  logic           zero_i,
  input  logic           ie_i,
  input  logic           irq_i,
  input  logic           rdy_i,
  output ctl_t           ctl_o,
  output logic           take_irq_o
);

  state_e st_q, st_d;
  logic   done;
  logic   is_store;

  assign is_store = (opcode_i == OP_STORE);

  always_comb begin
    ctl_o = '0;
    st_d  = st_q;
    done  = 1'b0;
    unique case (st_q)
      S_FA: begin
        ctl_o.mar_ld  = 1'b1;
        ctl_o.mar_sel = MAR_PC;
        st_d          = S_FM;
      end
      S_FM: begin
        ctl_o.mem_req = 1'b1;
        if (rdy_i) begin
          ctl_o.mbr_ld  = 1'b1;
          ctl_o.mbr_sel = MBR_MEM;
          st_d          = S_FI;
        end
      end
      S_FI: begin
        ctl_o.ir_ld  = 1'b1;
        ctl_o.pc_inc = 1'b1;
        st_d         = S_DC;
      end
      S_DC: begin
        if (ind_i) begin
          ctl_o.mar_ld  = 1'b1;
          ctl_o.mar_sel = MAR_MBR;
          st_d          = S_IM;
        end else begin
          st_d = S_XA;
        end
      end
      S_IM: begin
        ctl_o.mem_req = 1'b1;
        if (rdy_i) begin
          ctl_o.mbr_ld  = 1'b1;
          ctl_o.mbr_sel = MBR_MEM;
          st_d          = S_XA;
        end
      end
      S_XA: begin
        // MBR holds the effective address in its low bits here
        ctl_o.mar_ld  = 1'b1;
        ctl_o.mar_sel = MAR_MBR;
        unique case (opcode_i)
          OP_LOAD, OP_ADD: st_d = S_XM;
          OP_STORE: begin
            ctl_o.mbr_ld  = 1'b1;
            ctl_o.mbr_sel = MBR_ACC;
            st_d          = S_XM;
          end
          OP_JMP: begin
            ctl_o.pc_ld = 1'b1;
            done        = 1'b1;
          end
          OP_JZ: begin
            ctl_o.pc_ld = zero_i;
            done        = 1'b1;
          end
          OP_EI: begin
            ctl_o.ie_set = 1'b1;
            done         = 1'b1;
          end
          OP_DI: begin
            ctl_o.ie_clr = 1'b1;
            done         = 1'b1;
          end
          default: done = 1'b1;
        endcase
      end
      S_XM: begin
        ctl_o.mem_req = 1'b1;
        ctl_o.mem_we  = is_store;
        if (rdy_i) begin
          if (is_store) begin
            done = 1'b1;
          end else begin
            ctl_o.mbr_ld  = 1'b1;
            ctl_o.mbr_sel = MBR_MEM;
            st_d          = S_XW;
          end
        end
      end
      S_XW: begin
        ctl_o.acc_op = (opcode_i == OP_ADD) ? ACC_ADD : ACC_LOAD;
        done         = 1'b1;
      end
      S_NA: begin
        ctl_o.mbr_ld  = 1'b1;
        ctl_o.mbr_sel = MBR_PC;
        ctl_o.mar_ld  = 1'b1;
        ctl_o.mar_sel = MAR_SP;
        ctl_o.sp_dec  = 1'b1;
        ctl_o.ie_clr  = 1'b1;
        ctl_o.num_ld  = 1'b1;
        st_d          = S_NW;
      end
      S_NW: begin
        ctl_o.mem_req = 1'b1;
        ctl_o.mem_we  = 1'b1;
        if (rdy_i) st_d = S_VA;
      end
      S_VA: begin
        ctl_o.mar_ld  = 1'b1;
        ctl_o.mar_sel = MAR_VEC;
        st_d          = S_VM;
      end
      S_VM: begin
        ctl_o.mem_req = 1'b1;
        if (rdy_i) begin
          ctl_o.mbr_ld  = 1'b1;
          ctl_o.mbr_sel = MBR_MEM;
          st_d          = S_VL;
        end
      end
      S_VL: begin
        ctl_o.pc_ld = 1'b1;
        st_d        = S_FA;
      end
      default: st_d = S_FA;
    endcase
    take_irq_o = done && ie_i && irq_i;
    if (done) st_d = take_irq_o ? S_NA : S_FA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_FA;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/icyc_dpath.sv
module icyc_dpath
  import icyc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 23,
  parameter int unsigned NUMW     = 8,
  parameter int unsigned SP_RESET = 'h2F0,
  parameter int unsigned VEC_BASE = 'h300,
  localparam int unsigned OPW     = XLEN - AW - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  input  logic [NUMW-1:0] irq_num_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [AW-1:0]   mar_o,
  output logic [XLEN-1:0] mbr_o,
  output logic [OPW-1:0]  opcode_o,
  output logic            ind_o,
  output logic [AW-1:0]   pc_o,
  output logic [XLEN-1:0] acc_o,
  output logic [3:0]      flags_o,
  output logic            ie_o
);

  logic [AW-1:0]   pc_q, mar_q, sp_q;
  logic [XLEN-1:0] mbr_q, ir_q, acc_q;
  logic [NUMW-1:0] num_q;
  logic [3:0]      flg_q;
  logic            ie_q;
  logic [XLEN:0]   sum;
  logic            ovf;

  assign sum = {1'b0, acc_q} + {1'b0, mbr_q};
  assign ovf = (acc_q[XLEN-1] == mbr_q[XLEN-1]) && (sum[XLEN-1] != acc_q[XLEN-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      sp_q  <= AW'(SP_RESET);
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      num_q <= '0;
      flg_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      if (ctl_i.mar_ld) begin
        unique case (ctl_i.mar_sel)
          MAR_PC:  mar_q <= pc_q;
          MAR_MBR: mar_q <= mbr_q[AW-1:0];
          MAR_SP:  mar_q <= sp_q - 1'b1;
          default: mar_q <= AW'(VEC_BASE) + AW'(num_q);
        endcase
      end
      if (ctl_i.mbr_ld) begin
        unique case (ctl_i.mbr_sel)
          MBR_MEM: mbr_q <= rdata_i;
          MBR_ACC: mbr_q <= acc_q;
          default: mbr_q <= XLEN'(pc_q);
        endcase
      end
      if (ctl_i.ir_ld) ir_q <= mbr_q;
      if (ctl_i.pc_inc)     pc_q <= pc_q + 1'b1;
      else if (ctl_i.pc_ld) pc_q <= mbr_q[AW-1:0];
      if (ctl_i.sp_dec) sp_q <= sp_q - 1'b1;
      if (ctl_i.ie_set)      ie_q <= 1'b1;
      else if (ctl_i.ie_clr) ie_q <= 1'b0;
      if (ctl_i.num_ld) num_q <= irq_num_i;
      unique case (ctl_i.acc_op)
        ACC_LOAD: begin
          acc_q <= mbr_q;
          flg_q <= {1'b0, 1'b0, mbr_q[XLEN-1], (mbr_q == '0)};
        end
        ACC_ADD: begin
          acc_q <= sum[XLEN-1:0];
          flg_q <= {ovf, sum[XLEN], sum[XLEN-1], (sum[XLEN-1:0] == '0)};
        end
        default: ;
      endcase
    end
  end

  assign mar_o    = mar_q;
  assign mbr_o    = mbr_q;
  assign opcode_o = ir_q[XLEN-1 -: OPW];
  assign ind_o    = ir_q[AW];
  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign flags_o  = flg_q;
  assign ie_o     = ie_q;

endmodule

// File: rtl/icyc_core.sv
module icyc_core
  import icyc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 23,
  parameter int unsigned NUMW     = 8,
  parameter int unsigned SP_RESET = 'h2F0,
  parameter int unsigned VEC_BASE = 'h300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_i,
  input  logic [NUMW-1:0] irq_num_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_rdy_i,
  output logic [AW-1:0]   pc_o,
  output logic [XLEN-1:0] acc_o,
  output logic [3:0]      flags_o,
  output logic            int_en_o
);

  localparam int unsigned OPW = XLEN - AW - 1;

  ctl_t           ctl;
  logic [OPW-1:0] opcode;
  logic           ind;
  logic           take_irq;
  logic           pc_step;

  icyc_ctrl #(.OPW(OPW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .opcode_i  (opcode),
    .ind_i     (ind),
    .zero_i    (flags_o[0]),
    .ie_i      (int_en_o),
    .irq_i     (irq_i),
    .rdy_i     (mem_rdy_i),
    .ctl_o     (ctl),
    .take_irq_o(take_irq)
  );

  icyc_dpath #(
    .XLEN(XLEN), .AW(AW), .NUMW(NUMW),
    .SP_RESET(SP_RESET), .VEC_BASE(VEC_BASE)
  ) u_dpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .irq_num_i(irq_num_i),
    .rdata_i  (mem_rdata_i),
    .mar_o    (mem_addr_o),
    .mbr_o    (mem_wdata_o),
    .opcode_o (opcode),
    .ind_o    (ind),
    .pc_o     (pc_o),
    .acc_o    (acc_o),
    .flags_o  (flags_o),
    .ie_o     (int_en_o)
  );

  assign mem_req_o = ctl.mem_req;
  assign mem_we_o  = ctl.mem_we;
  assign pc_step   = ctl.pc_inc;

endmodule

// File: rtl/icyc_core_chk.sv
module icyc_core_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 23
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_req_i,
  input logic            mem_we_i,
  input logic [AW-1:0]   mem_addr_i,
  input logic [XLEN-1:0] mem_wdata_i,
  input logic            mem_rdy_i,
  input logic [AW-1:0]   pc_i,
  input logic            int_en_i,
  input logic            take_irq_i,
  input logic            pc_step_i
);

  a_r5_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_rdy_i |=> mem_req_i && $stable(mem_addr_i)
                                && $stable(mem_we_i) && $stable(mem_wdata_i));

  a_r5_we_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> mem_req_i);

  a_r3_pc_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_step_i |=> pc_i == $past(pc_i) + 1'b1);

  a_r8_take_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |-> int_en_i);

  a_r9_enable_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> ##1 !int_en_i);

  a_r9_push_return_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> ##1 (mem_req_i && mem_we_i && mem_wdata_i[AW-1:0] == $past(pc_i)));

endmodule

bind icyc_core icyc_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .mem_wdata_i(mem_wdata_o),
  .mem_rdy_i  (mem_rdy_i),
  .pc_i       (pc_o),
  .int_en_i   (int_en_o),
  .take_irq_i (take_irq),
  .pc_step_i  (pc_step)
);

// File: tb/icyc_core_bench.sv
module icyc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [7:0]  irq_num = '0;
  logic        mem_req, mem_we, mem_rdy;
  logic [22:0] mem_addr, pc;
  logic [31:0] mem_wdata, mem_rdata, acc;
  logic [3:0]  flags;
  logic        int_en;

  logic [31:0] mem [1024];
  int unsigned lat = 0;
  int unsigned wcnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  logic [22:0] exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_req[$];

  always #10 clk = ~clk;

  icyc_core u_icyc_core (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_num_i(irq_num),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .pc_o(pc), .acc_o(acc), .flags_o(flags), .int_en_o(int_en)
  );

  assign mem_rdy   = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(negedge clk) begin
    if (!mem_req)        wcnt <= 0;
    else if (wcnt < lat) wcnt <= wcnt + 1;
  end

  // monitor: every accepted write is popped against the expected queue
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_we && mem_rdy) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      n_chk++;
      if (exp_addr.size() == 0) begin
        n_bad++;
        $display("FAIL R6/R10 unexpected write: act %h@%h exp none", mem_wdata, mem_addr);
      end else begin
        if (mem_addr !== exp_addr[0] || mem_wdata !== exp_data[0]) begin
          n_bad++;
          $display("FAIL %s write: act %h@%h exp %h@%h", exp_req[0],
                   mem_wdata, mem_addr, exp_data[0], exp_addr[0]);
        end
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_req.pop_front());
      end
    end
  end

  function automatic logic [31:0] ins(logic [7:0] op, logic ind, logic [22:0] a);
    return {op, ind, a};
  endfunction

  task automatic expect_wr(string req, logic [22:0] a, logic [31:0] d);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_req.push_back(req);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic start(int unsigned l);
    @(negedge clk);
    rst_n = 1'b0;
    lat   = l;
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 acc", acc, 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 int_en", 32'(int_en), 0);
    chk("R1 req", 32'(mem_req), 0);
    rst_n = 1'b1;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_addr.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk("R6 pending writes", exp_addr.size(), 0);
    exp_addr.delete(); exp_data.delete(); exp_req.delete();
    repeat (150) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // program 1: data path, indirect, flags, conditional branch; two wait cycles
    irq = 1'b0;
    clear_mem();
    mem[0]  = ins(8'h01, 1'b0, 23'h40);   // load 5
    mem[1]  = ins(8'h03, 1'b1, 23'h41);   // add indirect -> 12 (R4)
    mem[2]  = ins(8'h02, 1'b0, 23'h50);   // store 12
    mem[3]  = ins(8'h03, 1'b0, 23'h43);   // add -12 -> 0, carry
    mem[4]  = ins(8'h05, 1'b0, 23'h07);   // jz taken (R7)
    mem[5]  = ins(8'h02, 1'b0, 23'h51);   // skipped
    mem[7]  = ins(8'h02, 1'b1, 23'h44);   // store indirect to 0x52
    mem[8]  = ins(8'h01, 1'b0, 23'h45);   // load 0x7fffffff
    mem[9]  = ins(8'h03, 1'b0, 23'h46);   // add 1 -> overflow
    mem[10] = ins(8'h05, 1'b0, 23'h0C);   // jz not taken (R7)
    mem[11] = ins(8'h02, 1'b0, 23'h53);
    mem[12] = ins(8'h04, 1'b0, 23'h0C);   // loop
    mem['h40] = 32'd5;
    mem['h41] = 32'h42;
    mem['h42] = 32'd7;
    mem['h43] = 32'hFFFF_FFF4;
    mem['h44] = 32'h52;
    mem['h45] = 32'h7FFF_FFFF;
    mem['h46] = 32'd1;
    expect_wr("R4/R6", 23'h50, 32'd12);
    expect_wr("R7 jz taken", 23'h52, 32'd0);
    expect_wr("R7 jz not taken", 23'h53, 32'h8000_0000);
    start(2);
    drain();
    chk("R6 acc after overflow add", acc, 32'h8000_0000);
    chk("R6 flags v,c,n,z", 32'(flags), 32'hA);
    chk("R3 fetch loop pc", 32'(pc == 23'h0C || pc == 23'h0D), 1);

    // program 2: interrupt entry with enable set; zero wait
    clear_mem();
    irq = 1'b1;
    irq_num = 8'd5;
    mem[0] = ins(8'h06, 1'b0, 23'h0);     // enable, counts after next instr (R8)
    mem[1] = ins(8'h01, 1'b0, 23'h40);    // load 9, then interrupt
    mem[2] = ins(8'h02, 1'b0, 23'h50);    // never reached
    mem['h40]  = 32'd9;
    mem['h305] = 32'h20;                  // vector 5
    mem['h20]  = ins(8'h02, 1'b0, 23'h60);
    mem['h21]  = ins(8'h04, 1'b0, 23'h21);
    expect_wr("R9 push return pc", 23'h2EF, 32'd2);
    expect_wr("R9 handler via vector", 23'h60, 32'd9);
    start(0);
    drain();
    chk("R9 enable cleared", 32'(int_en), 0);
    chk("R6 load value", acc, 32'd9);
    chk("R6 load flags", 32'(flags), 0);

    // program 3: irq held while enable clear; one wait cycle
    clear_mem();
    irq = 1'b1;
    irq_num = 8'd3;
    mem[0] = ins(8'h01, 1'b0, 23'h40);
    mem[1] = ins(8'h02, 1'b0, 23'h50);
    mem[2] = ins(8'h04, 1'b0, 23'h02);
    mem[3] = ins(8'h00, 1'b0, 23'h0);     // no-op opcode never reached (R2)
    mem['h40] = 32'h8000_0033;
    expect_wr("R10 ignored irq", 23'h50, 32'h8000_0033);
    start(1);
    drain();
    chk("R10 still disabled", 32'(int_en), 0);
    chk("R10 pc in own loop", 32'(pc == 23'h02 || pc == 23'h03), 1);
    chk("R6 load sign flag", 32'(flags), 32'h2);
    irq = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule